// File: doc/BRIEF.md
# Snooze Sequencer for a Synchronous Memory

This block sequences a low-power snooze state for a synchronous memory. A sleep request that arrives with no fixed timing to the clock is first retimed through a short flop chain. The block then steps through four phases: normal operation, a fixed entry dwell, the snooze state itself, and a fixed recovery dwell. In every phase other than normal operation it raises an inhibit output. The surrounding memory logic uses that output to refuse accesses and to keep the data bus in high impedance, so the array keeps its contents.

The block also watches the three chip enables and the two address strobes. If the device is still selected when a snooze begins, or if any enable or strobe is active during recovery, a sticky protocol-error flag is set. Only a synchronous reset clears it. While the memory is in the snooze state, those inputs are ignored.

Top module: `snooze_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in normal operation with access_inhibit, sleep_active and proto_err all low. While sleep_req stays low, all three outputs stay low.
- R2: If sleep_req is high before clock edge k and stays high, access_inhibit goes high after edge k+2 and sleep_active goes high after edge k+4.
- R3: If sleep_req goes low before edge m while the block is in the snooze state, sleep_active goes low after edge m+2. access_inhibit stays high for two more cycles and goes low after edge m+4.
- R4: The entry dwell and the recovery dwell always last exactly two cycles. A request pulse that is seen for only one cycle still runs entry, one snooze cycle, and recovery in full.
- R5: access_inhibit is high in the entry, snooze and recovery phases and low only in normal operation. The data bus therefore stays in high impedance throughout both entry and exit.
- R6: While the block is in the snooze state, active chip enables or strobes set no error and do not change any output.
- R7: The device counts as selected when cs1_n is 0, cs2 is 1 and cs3_n is 0. If it is selected at the edge where entry begins (edge k+2 in R2), proto_err is set after that edge. Selection at earlier edges sets nothing.
- R8: An enable counts as active when cs1_n is 0, cs2 is 1 or cs3_n is 0. A strobe counts as active when cpu_strobe_n or ctl_strobe_n is 0. If any enable or strobe is active at either edge of the recovery dwell (edges m+3 and m+4 in R3), proto_err is set after that edge.
- R9: Once set, proto_err stays high in every phase until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Snooze request, active high, not timed to clk |
| cs1_n | input | 1 | Chip enable one, active low |
| cs2 | input | 1 | Chip enable two, active high |
| cs3_n | input | 1 | Chip enable three, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| access_inhibit | output | 1 | Blocks accesses and floats the data bus |
| sleep_active | output | 1 | High while in the snooze state |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The sequencer is tried with several request patterns:
- A long clean request shows the entry and exit latencies.
- A one-cycle pulse shows that each dwell runs to completion whatever the request does.
- A request raised while the device is selected at the first entry edge, next to one where selection ends just before that edge, separates the edge at which selection is checked from its neighbours.
- Activity on the enables and strobes at the last snooze edge, then at each recovery edge, separates the ignored window from the checked one.
- A reset after an error shows that the flag is sticky and is cleared only by reset.

// File: rtl/snooze_ctrl.sv
module snooze_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DWELL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic cs1_n,
  input  logic cs2,
  input  logic cs3_n,
  input  logic cpu_strobe_n,
  input  logic ctl_strobe_n,
  output logic access_inhibit,
  output logic sleep_active,
  output logic proto_err
);
  localparam int CW = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  typedef enum logic [1:0] {ST_ACTIVE, ST_ENTER, ST_SLEEP, ST_RECOVER} state_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s;
  state_t                 state;
  logic [CW-1:0]          cnt;
  logic                   err_q;
  logic                   selected;
  logic                   any_busy;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};
  end

  assign req_s    = sync_q[SYNC_STAGES-1];
  assign selected = !cs1_n && cs2 && !cs3_n;
  assign any_busy = !cs1_n || cs2 || !cs3_n || !cpu_strobe_n || !ctl_strobe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      case (state)
        ST_ACTIVE: begin
          if (req_s) begin
            state <= ST_ENTER;
            cnt   <= '0;
            if (selected) err_q <= 1'b1;
          end
        end
        ST_ENTER: begin
          if (cnt == LAST) begin
            state <= ST_SLEEP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (!req_s) begin
            state <= ST_RECOVER;
            cnt   <= '0;
          end
        end
        default: begin
          if (any_busy) err_q <= 1'b1;
          if (cnt == LAST) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign access_inhibit = (state != ST_ACTIVE);
  assign sleep_active   = (state == ST_SLEEP);
  assign proto_err      = err_q;
endmodule

// File: rtl/snooze_ctrl_chk.sv
module snooze_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cs1_n,
  input logic cs2,
  input logic cs3_n,
  input logic access_inhibit,
  input logic sleep_active,
  input logic proto_err
);
  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (rst)
    !access_inhibit |-> !sleep_active);

  a_r2_entry_dwell: assert property (@(posedge clk) disable iff (rst)
    ($rose(access_inhibit) && !sleep_active) |=> (access_inhibit && !sleep_active));

  a_r5_inhibit_before_sleep: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_active) |-> $past(access_inhibit));

  a_r3_exit_keeps_inhibit: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_active) |-> (access_inhibit ##1 access_inhibit));

  a_r7_selected_at_entry: assert property (@(posedge clk) disable iff (rst)
    ($rose(access_inhibit) && $past(!cs1_n && cs2 && !cs3_n)) |-> proto_err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind snooze_ctrl snooze_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
  .access_inhibit(access_inhibit), .sleep_active(sleep_active),
  .proto_err(proto_err)
);

// File: tb/snooze_ctrl_test.sv
module snooze_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1, cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1;
  logic access_inhibit, sleep_active, proto_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  localparam logic [4:0] IDLE = 5'b10111;
  localparam logic [4:0] SEL  = 5'b01011;
  localparam logic [4:0] STRB = 5'b10110;
  localparam logic [4:0] EN2  = 5'b11111;

  always #2 clk = ~clk;

  snooze_ctrl uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .access_inhibit(access_inhibit), .sleep_active(sleep_active),
    .proto_err(proto_err)
  );

  // expected bits: {proto_err, sleep_active, access_inhibit}
  task automatic step(input logic r, input logic [4:0] pins, input logic rs,
                      input logic [2:0] exp, input string tag);
    @(negedge clk);
    sleep_req = r;
    {cs1_n, cs2, cs3_n, cpu_strobe_n, ctl_strobe_n} = pins;
    rst = rs;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      logic [2:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {proto_err, sleep_active, access_inhibit};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got err/sleep/inh=%b expected %b", t, a, e);
      end
    end
  end

  task automatic clean_entry();
    step(1, IDLE, 0, 3'b000, "R2 sync stage 1");
    step(1, IDLE, 0, 3'b000, "R2 sync stage 2");
    step(1, IDLE, 0, 3'b001, "R2 entry begins");
    step(1, IDLE, 0, 3'b001, "R4 entry dwell");
    step(1, IDLE, 0, 3'b011, "R2 asleep");
  endtask

  initial begin
    step(0, IDLE, 1, 3'b000, "R1 reset");
    step(0, IDLE, 1, 3'b000, "R1 reset");
    for (int i = 0; i < 4; i++) step(0, IDLE, 0, 3'b000, "R1 idle low request");

    clean_entry();
    step(1, SEL,  0, 3'b011, "R6 selected while asleep");
    step(1, STRB, 0, 3'b011, "R6 strobe while asleep");
    step(0, SEL,  0, 3'b011, "R3 drop seen edge m");
    step(0, SEL,  0, 3'b011, "R3 still asleep m+1");
    step(0, SEL,  0, 3'b001, "R6 last asleep edge ignored, R3 recovery");
    step(0, IDLE, 0, 3'b001, "R5 recovery inhibit");
    step(0, IDLE, 0, 3'b000, "R3 active after m+4");
    step(0, IDLE, 0, 3'b000, "R8 clean recovery no error");

    step(1, IDLE, 0, 3'b000, "R7 sync 1");
    step(1, IDLE, 0, 3'b000, "R7 sync 2");
    step(1, SEL,  0, 3'b101, "R7 selected at entry");
    step(1, IDLE, 0, 3'b101, "R9 sticky entering");
    step(1, IDLE, 0, 3'b111, "R9 sticky asleep");
    step(0, IDLE, 0, 3'b111, "R9 m");
    step(0, IDLE, 0, 3'b111, "R9 m+1");
    step(0, IDLE, 0, 3'b101, "R9 recovering");
    step(0, IDLE, 0, 3'b101, "R9 recovering");
    step(0, IDLE, 0, 3'b100, "R9 sticky active");
    step(0, IDLE, 1, 3'b000, "R9 reset clears");
    step(0, IDLE, 0, 3'b000, "R1 after reset");

    clean_entry();
    step(0, IDLE, 0, 3'b011, "R3 m");
    step(0, IDLE, 0, 3'b011, "R3 m+1");
    step(0, IDLE, 0, 3'b001, "R3 m+2");
    step(0, IDLE, 0, 3'b001, "R8 first recovery edge clean");
    step(0, STRB, 0, 3'b100, "R8 strobe at second recovery edge");
    step(0, IDLE, 1, 3'b000, "R9 reset clears");

    clean_entry();
    step(0, IDLE, 0, 3'b011, "R3 m");
    step(0, IDLE, 0, 3'b011, "R3 m+1");
    step(0, IDLE, 0, 3'b001, "R3 m+2");
    step(0, EN2,  0, 3'b101, "R8 cs2 at first recovery edge");
    step(0, IDLE, 0, 3'b100, "R8 done, flag held");
    step(0, IDLE, 1, 3'b000, "R9 reset clears");

    step(1, IDLE, 0, 3'b000, "R4 pulse sync 1");
    step(0, IDLE, 0, 3'b000, "R4 pulse sync 2");
    step(0, IDLE, 0, 3'b001, "R4 entry begins");
    step(0, IDLE, 0, 3'b001, "R4 entry dwell");
    step(0, IDLE, 0, 3'b011, "R4 one asleep cycle");
    step(0, IDLE, 0, 3'b001, "R4 recovery");
    step(0, IDLE, 0, 3'b001, "R4 recovery dwell");
    step(0, IDLE, 0, 3'b000, "R4 active");

    step(1, SEL,  0, 3'b000, "R7 selected edge k ignored");
    step(1, SEL,  0, 3'b000, "R7 selected edge k+1 ignored");
    step(1, IDLE, 0, 3'b001, "R7 deselected at entry edge");
    step(1, IDLE, 0, 3'b001, "R5 entry inhibit");
    step(1, IDLE, 0, 3'b011, "R2 asleep");
    step(0, IDLE, 0, 3'b011, "R3 m");
    step(0, IDLE, 0, 3'b011, "R3 m+1");
    step(0, IDLE, 0, 3'b001, "R3 m+2");
    step(0, IDLE, 0, 3'b001, "R8 clean");
    step(0, IDLE, 0, 3'b000, "R3 active no error");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule